// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

This block collects level-sensitive requests from up to 32 peripherals and drives a single interrupt line towards a host processor. The host reaches it through a small word-addressed register port. The port holds a control word, a sampled request view, an enable mask, an in-service set and an acknowledge/vector word. When the line is raised, the host writes the acknowledge bit. It then reads the number of the winning source from bits 15:11 of the vector word, and ends service later by writing a one to that source's in-service bit.

Among ordinary sources the higher number wins. The control word can lift one chosen source above all others. A source that is in service holds back every request of equal or lower priority, so higher-priority sources can still interrupt a running handler. Vector 0 is kept as the error vector. It is returned when an acknowledge arrives and no request is eligible any more, for example because a peripheral withdrew its level or the host masked it in between. Acknowledging the error vector puts nothing in service.

Register map (word index on `reg_addr`): 0 control (bit 0 global enable, bits 5:1 promoted source), 1 request view (read only), 2 enable mask, 3 in-service (write one to clear), 4 vector (write bit 0 = acknowledge; read returns the vector in bits 15:11).

Top module: `vic_ctrl`

## Requirements
- R1: After reset every register reads zero, the global enable is off and `irq_o` is low.
- R2: A source drives `irq_o` only while its bit in the enable mask (index 2) is one; a zero bit masks it.
- R3: `irq_o` stays low while control bit 0 (global enable) is zero, whatever the requests.
- R4: Requests are levels: `irq_o` rises one clock after an eligible request is raised and falls one clock after the request is removed. It is high only when some source is requested, enabled and not in service.
- R5: Among eligible sources the higher source number is chosen.
- R6: The source named in control bits 5:1 outranks all other sources when it is eligible. If it is not eligible, the fixed order applies.
- R7: Writing 1 to bit 0 of the vector word (index 4) latches the chosen source number and sets its in-service bit. A read of index 4 returns that number in bits 15:11 and zero elsewhere.
- R8: A set in-service bit holds `irq_o` low for requests of equal or lower priority. A request of higher priority still raises it.
- R9: Writing a word to the in-service register (index 3) clears exactly the bits that are one in the word and leaves the others unchanged.
- R10: An acknowledge with no eligible request latches vector 0 and changes no in-service bit.
- R11: Reading the vector word without a new acknowledge returns the last latched value.
- R12: Request input 0 is reserved for the error vector and is ignored: it never appears in the request view, never raises `irq_o` and is never put in service.
- R13: The request view (index 1) shows the request levels sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NUM_SRC | Level requests from peripherals; bit 0 reserved |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench targets the promotion field, first with its source eligible and then with it masked or idle. A resolver that ignored the field would return the plain highest number, and one that promoted without checking eligibility would hand out a source that is not requesting. Nesting is exercised by putting a source in service and then offering both a lower and a higher request. A controller that blocked everything, or nothing, would get the line level wrong. The withdraw-then-acknowledge race must yield vector 0 with the in-service set untouched. The test also clears one in-service bit among several and expects the rest to remain set, which catches a design that clears the whole register on write.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 3;
   localparam int VFIELD_W = 5;
   localparam int VFIELD_LSB = 11;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_REQ  = 3'd1;
   localparam logic [ADDR_W-1:0] A_ENA  = 3'd2;
   localparam logic [ADDR_W-1:0] A_SVC  = 3'd3;
   localparam logic [ADDR_W-1:0] A_VEC  = 3'd4;
endpackage

// File: rtl/vic_prio_sel.sv
module vic_prio_sel #(
   parameter int NUM_SRC = 32,
   parameter int VW      = $clog2(NUM_SRC),
   parameter int RW      = VW + 1
) (
   input  logic [NUM_SRC-1:0] elig,
   input  logic [VW-1:0]      promo,
   output logic               cand_vld,
   output logic [VW-1:0]      cand_vec,
   output logic [RW-1:0]      cand_rank
);
   logic [VW-1:0] fixed_vec;
   logic          promo_hit;

   always_comb begin
      cand_vld  = 1'b0;
      fixed_vec = '0;
      for (int i = NUM_SRC - 1; i >= 1; i--) begin
         if (elig[i] && !cand_vld) begin
            cand_vld  = 1'b1;
            fixed_vec = VW'(i);
         end
      end
   end

   assign promo_hit = (promo != '0) && elig[promo];
   assign cand_vec  = promo_hit ? promo : fixed_vec;
   assign cand_rank = promo_hit ? RW'(NUM_SRC) : RW'(fixed_vec);
endmodule

// File: rtl/vic_nest_gate.sv
module vic_nest_gate #(
   parameter int NUM_SRC = 32,
   parameter int VW      = $clog2(NUM_SRC),
   parameter int RW      = VW + 1
) (
   input  logic [NUM_SRC-1:0] svc,
   input  logic [VW-1:0]      promo,
   input  logic               cand_vld,
   input  logic [RW-1:0]      cand_rank,
   output logic               active
);
   logic [RW-1:0] bit_rank [NUM_SRC];
   logic [RW-1:0] svc_rank;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
      if (g == 0) begin : g_err
         assign bit_rank[g] = '0;
      end else begin : g_src
         assign bit_rank[g] = !svc[g] ? '0 :
                              (promo == VW'(g)) ? RW'(NUM_SRC) : RW'(g);
      end
   end

   always_comb begin
      svc_rank = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (bit_rank[i] > svc_rank) svc_rank = bit_rank[i];
      end
   end

   assign active = cand_vld && (cand_rank > svc_rank);
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
   import vic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter bit REQ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_o
);
   localparam int VW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int RW = VW + 1;

   if (NUM_SRC < 2 || NUM_SRC > DATA_W || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_bad_cfg
      $error("vic_ctrl: NUM_SRC must be a power of two from 2 to 32");
   end
   if (VW > VFIELD_W) begin : g_bad_vw
      $error("vic_ctrl: vector does not fit the vector field");
   end

   logic               en_q;
   logic [VW-1:0]      promo_q;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] svc_q;
   logic [NUM_SRC-1:0] svc_d;
   logic [VW-1:0]      vec_q;
   logic [NUM_SRC-1:0] elig;
   logic               cand_vld;
   logic [VW-1:0]      cand_vec;
   logic [RW-1:0]      cand_rank;
   logic               act_vld;
   logic               ack_fire;
   logic               w1c_fire;
   logic [NUM_SRC-1:0] req_live;

   assign req_live = {src_req[NUM_SRC-1:1], 1'b0};

   if (REQ_REG) begin : g_req_reg
      logic [NUM_SRC-1:0] pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q <= '0;
         else        pend_q <= req_live;
      end
      assign pend = pend_q;
   end else begin : g_req_comb
      assign pend = req_live;
   end

   assign elig     = pend & mask_q & ~svc_q;
   assign ack_fire = reg_we && (reg_addr == A_VEC) && reg_wdata[0];
   assign w1c_fire = reg_we && (reg_addr == A_SVC);

   vic_prio_sel #(.NUM_SRC(NUM_SRC), .VW(VW), .RW(RW)) u_sel (
      .elig      (elig),
      .promo     (promo_q),
      .cand_vld  (cand_vld),
      .cand_vec  (cand_vec),
      .cand_rank (cand_rank)
   );

   vic_nest_gate #(.NUM_SRC(NUM_SRC), .VW(VW), .RW(RW)) u_gate (
      .svc       (svc_q),
      .promo     (promo_q),
      .cand_vld  (cand_vld),
      .cand_rank (cand_rank),
      .active    (act_vld)
   );

   always_comb begin
      svc_d = svc_q;
      if (w1c_fire) svc_d = svc_q & ~reg_wdata[NUM_SRC-1:0];
      if (ack_fire && act_vld) svc_d[cand_vec] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         promo_q <= '0;
         mask_q  <= '0;
         svc_q   <= '0;
         vec_q   <= '0;
      end else begin
         svc_q <= svc_d;
         if (reg_we && reg_addr == A_CTRL) begin
            en_q    <= reg_wdata[0];
            promo_q <= reg_wdata[VW:1];
         end
         if (reg_we && reg_addr == A_ENA) mask_q <= reg_wdata[NUM_SRC-1:0];
         if (ack_fire) vec_q <= act_vld ? cand_vec : '0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = DATA_W'({promo_q, en_q});
         A_REQ:   reg_rdata = DATA_W'(pend);
         A_ENA:   reg_rdata = DATA_W'(mask_q);
         A_SVC:   reg_rdata = DATA_W'(svc_q);
         A_VEC:   reg_rdata = DATA_W'({VFIELD_W'(vec_q), {VFIELD_LSB{1'b0}}});
         default: reg_rdata = '0;
      endcase
   end

   assign irq_o = en_q && act_vld;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
   parameter int NUM_SRC = 32,
   parameter int VW      = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_o,
   input logic               en_q,
   input logic               ack_fire,
   input logic               w1c_fire,
   input logic               act_vld,
   input logic [VW-1:0]      vec_q,
   input logic [NUM_SRC-1:0] svc_q,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [31:0]        reg_wdata
);
   p_gate_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !irq_o);

   p_line_has_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((pend & mask_q & ~svc_q) != '0));

   p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && act_vld) |=> svc_q[vec_q]);

   p_clear_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      w1c_fire |=> ((svc_q & $past(reg_wdata[NUM_SRC-1:0])) == '0));

   p_err_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !act_vld) |=> (vec_q == '0 && $stable(svc_q)));

   p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_fire |=> $stable(vec_q));

   p_src0_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_q[0] && !pend[0]);
endmodule

bind vic_ctrl vic_ctrl_chk #(.NUM_SRC(NUM_SRC), .VW(VW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .en_q      (en_q),
   .ack_fire  (ack_fire),
   .w1c_fire  (w1c_fire),
   .act_vld   (act_vld),
   .vec_q     (vec_q),
   .svc_q     (svc_q),
   .pend      (pend),
   .mask_q    (mask_q),
   .reg_wdata (reg_wdata)
);

// File: tb/vic_ctrl_bench.sv
`timescale 1ns/1ps
module vic_ctrl_bench;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   vic_ctrl #(.NUM_SRC(NS)) u_vic_ctrl (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o)
   );

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] ena;
      logic [4:0]  promo;
      logic        gen;
      logic        irq;
      logic [4:0]  vec;
   } row_t;

   localparam int NROW = 10;
   localparam row_t TBL [NROW] = '{
      '{32'h0000_0010, 32'h0000_0010, 5'd0, 1'b1, 1'b1, 5'd4},   // R2 enabled
      '{32'h0000_0010, 32'h0000_0000, 5'd0, 1'b1, 1'b0, 5'd0},   // R2 masked, R10
      '{32'h0000_0010, 32'h0000_0010, 5'd0, 1'b0, 1'b0, 5'd4},   // R3 gate off
      '{32'h8000_0022, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b1, 5'd31},  // R5
      '{32'h0000_0022, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b1, 5'd5},   // R5
      '{32'h8000_0022, 32'hFFFF_FFFF, 5'd1, 1'b1, 1'b1, 5'd1},   // R6 promoted
      '{32'h0000_0022, 32'hFFFF_FFFF, 5'd7, 1'b1, 1'b1, 5'd5},   // R6 idle promo
      '{32'h0000_0001, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, 5'd0},   // R12
      '{32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 1'b1, 1'b0, 5'd0},   // R2 top masked
      '{32'h0000_0006, 32'h0000_0004, 5'd1, 1'b1, 1'b1, 5'd2}    // R6 masked promo
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 reg", d, 32'h0);
      end
      check("R1 irq", {31'b0, irq_o}, 32'h0);

      // table walk
      for (int i = 0; i < NROW; i++) begin
         wr(3'd2, TBL[i].ena);
         wr(3'd0, {26'b0, TBL[i].promo, TBL[i].gen});
         wr(3'd3, 32'hFFFF_FFFF);
         src_req = TBL[i].src;
         @(negedge clk);
         check($sformatf("R2/R3/R5 row%0d irq", i), {31'b0, irq_o}, {31'b0, TBL[i].irq});
         wr(3'd4, 32'h1);
         rd(3'd4, d);
         check($sformatf("R7/R6 row%0d vec", i), d, {16'b0, TBL[i].vec, 11'b0});
         wr(3'd3, 32'hFFFF_FFFF);
      end

      // R13 / R12 request view
      src_req = 32'h8000_0005;
      @(negedge clk);
      rd(3'd1, d);
      check("R13 view", d, 32'h8000_0004);

      // R4 level timing
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd0, 32'h1);
      src_req = '0;
      @(negedge clk);
      check("R4 idle", {31'b0, irq_o}, 32'h0);
      src_req = 32'h0000_0100;
      #1;
      check("R4 not yet", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      check("R4 rise", {31'b0, irq_o}, 32'h1);
      src_req = '0;
      #1;
      check("R4 hold", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R4 fall", {31'b0, irq_o}, 32'h0);

      // R8 nesting, R9 partial clear, R11 hold
      src_req = 32'h0000_0108;
      @(negedge clk);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R7 vec8", d, 32'h0000_4000);
      rd(3'd3, d);
      check("R7 svc8", d, 32'h0000_0100);
      check("R8 lower blocked", {31'b0, irq_o}, 32'h0);
      src_req = 32'h0000_1108;
      @(negedge clk);
      check("R8 higher passes", {31'b0, irq_o}, 32'h1);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R8 vec12", d, 32'h0000_6000);
      rd(3'd3, d);
      check("R8 svc both", d, 32'h0000_1100);
      src_req = 32'h0000_0108;
      wr(3'd3, 32'h0000_1000);
      rd(3'd3, d);
      check("R9 partial", d, 32'h0000_0100);
      check("R8 still blocked", {31'b0, irq_o}, 32'h0);
      rd(3'd4, d);
      check("R11 hold a", d, 32'h0000_6000);
      @(negedge clk);
      rd(3'd4, d);
      check("R11 hold b", d, 32'h0000_6000);
      wr(3'd3, 32'h0000_0100);
      rd(3'd3, d);
      check("R9 empty", d, 32'h0);
      check("R8 released", {31'b0, irq_o}, 32'h1);

      // R6 promoted source outranks an in-service higher number
      wr(3'd0, {26'b0, 5'd2, 1'b1});
      src_req = 32'h0010_0000;
      @(negedge clk);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R6 vec20", d, 32'h0000_A000);
      src_req = 32'h0010_0004;
      @(negedge clk);
      check("R6 promo over svc", {31'b0, irq_o}, 32'h1);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R6 vec2", d, 32'h0000_1000);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd0, 32'h1);

      // R10 withdraw race
      src_req = 32'h0000_0040;
      @(negedge clk);
      check("R10 raised", {31'b0, irq_o}, 32'h1);
      src_req = '0;
      @(negedge clk);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R10 err vec", d, 32'h0);
      rd(3'd3, d);
      check("R10 svc untouched", d, 32'h0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule